// File: doc/BRIEF.md
# Dual-Threshold Watchdog Timer

The block is a watchdog counter behind a two-word register port. A control/status word holds two 4-bit threshold codes, three enable bits and two sticky event flags. A write-only service word takes a two-step unlock key. While counting is enabled, a free-running up-counter advances once per clock. Two power-of-two thresholds are decoded from the codes and compared with the counter. The lower threshold normally sets the interrupt flag. The higher one sets the reset flag and, when allowed, issues a one-cycle reset request.

Software keeps the system alive by writing the key 0xA5 and then 0x5A to the service word. This returns the counter to zero before either threshold is met. The key checker is a two-state machine:
- IDLE goes to ARMED on a service write of 0xA5. Any other service write leaves it in IDLE.
- ARMED goes back to IDLE on every service write. When that write carries 0x5A, the counter also restarts (the FIRE transition). Any other value cancels the pending first step (the ABORT transition).
- Writes to the control word do not affect this machine.

A code n selects a period of 2^(CNT_W-1-n) clocks. With the default CNT_W of 32, code 0 gives 2^31 clocks and code 15 gives 2^16. A smaller CNT_W shortens every period, so that all codes can be tried in short runs.

Top module: `dual_wdog`

## Requirements
- R1: After reset, the control word reads 0, and both `irq` and `rst_req` are low.
- R2: Control bits 3:0 hold the interrupt code n, with period P = 2^(CNT_W-1-n). Bit 9, the interrupt flag, becomes 1 on the clock edge where the count reaches P. With the counter enabled from zero, that is the P-th enabled edge.
- R3: Control bits 7:4 hold the reset code, which uses the same mapping. Bit 31, the reset flag, becomes 1 on the edge where the count reaches the reset period, whether or not bit 11 is set.
- R4: The counter advances only on edges where control bit 8 is 1. Otherwise it holds its value, and no flag can be set.
- R5: `irq` is high exactly when the interrupt flag (bit 9) and control bit 10 are both 1.
- R6: `rst_req` goes high for exactly one cycle, following the edge where the reset period is reached, and only if control bit 11 is 1.
- R7: Both flags stay set until a control write carries 0 in that flag's bit. A write carrying 1 there never sets or changes the flag. If a threshold is reached in the same cycle as a clearing write, the flag is set.
- R8: A service write (offset 0x04) whose bits 7:0 are 0xA5, followed directly by a service write whose bits 7:0 are 0x5A, resets the counter to 0 on the second write. Bits 31:8 of service writes are ignored.
- R9: A service write with any other value cancels a pending 0xA5 step, and this includes a second 0xA5. A lone 0x5A does not restart the counter.
- R10: Control fields read back at the bit positions listed above, with all other bits 0. The service word always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | ADDR_W | Byte offset: 0x00 control, 0x04 service |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt level |
| rst_req | output | 1 | One-cycle reset request pulse |

## Verification
Threshold decoding is tried with the shortest code, a middle code and the longest code (0). Sampling one edge before and at the expected period separates an off-by-one count from a wrong shift. The service key is driven as:
- the correct pair, with junk in the upper bits;
- a doubled first key;
- a foreign value between the two keys;
- the keys in reverse order.

Only the correct pair moves the interrupt flag later. A disable window in the middle of counting shows the difference between holding the count and clearing it. Running the reset threshold with and without reset generation separates the sticky flag from the request pulse.

// File: rtl/dwd_pkg.sv
package dwd_pkg;
    typedef enum logic {
        FEED_IDLE  = 1'b0,
        FEED_ARMED = 1'b1
    } feed_st_e;

    localparam logic [7:0] KEY_ARM  = 8'hA5;
    localparam logic [7:0] KEY_FIRE = 8'h5A;

    // control word bit positions (software-visible)
    localparam int B_ICODE  = 0;
    localparam int B_RCODE  = 4;
    localparam int B_RUN    = 8;
    localparam int B_IFLAG  = 9;
    localparam int B_IEN    = 10;
    localparam int B_REN    = 11;
    localparam int B_RFLAG  = 31;
endpackage

// File: rtl/dwd_feed_fsm.sv
module dwd_feed_fsm
    import dwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       feed_wr_i,
    input  logic [7:0] key_i,
    output logic       restart_o
);
    feed_st_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FEED_IDLE:  if (feed_wr_i && key_i == KEY_ARM) state_d = FEED_ARMED;
            FEED_ARMED: if (feed_wr_i) state_d = FEED_IDLE;   // FIRE or ABORT
            default:    state_d = FEED_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FEED_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        restart_o = 1'b0;
        unique case (state_q)
            FEED_IDLE:  restart_o = 1'b0;
            FEED_ARMED: restart_o = feed_wr_i && (key_i == KEY_FIRE);
            default:    restart_o = 1'b0;
        endcase
    end

    // R9: any service write while armed returns to idle
    a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FEED_ARMED && feed_wr_i) |=> (state_q == FEED_IDLE));
endmodule

// File: rtl/dwd_thresh.sv
module dwd_thresh #(
    parameter int CNT_W = 32
) (
    input  logic [3:0]       code_i,
    input  logic [CNT_W-1:0] cnt_nxt_i,
    output logic             match_o
);
    localparam int TOP = CNT_W - 1;
    localparam int SHW = $clog2(CNT_W);

    logic [SHW-1:0]   shamt;
    logic [CNT_W-1:0] period;

    assign shamt   = SHW'(TOP) - SHW'(code_i);
    assign period  = CNT_W'(1) << shamt;
    assign match_o = (cnt_nxt_i == period);
endmodule

// File: rtl/dwd_counter.sv
module dwd_counter #(
    parameter int CNT_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            restart_i,
    input  logic [1:0][3:0] code_i,
    output logic [1:0]      hit_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [1:0]       match;

    assign cnt_nxt = cnt_q + CNT_W'(1);

    for (genvar g = 0; g < 2; g++) begin : g_thr
        dwd_thresh #(.CNT_W(CNT_W)) u_thr (
            .code_i    (code_i[g]),
            .cnt_nxt_i (cnt_nxt),
            .match_o   (match[g])
        );
        assign hit_o[g] = en_i && !restart_i && match[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt_q <= '0;
        else if (restart_i) cnt_q <= '0;
        else if (en_i)      cnt_q <= cnt_nxt;
    end

    // R4: count holds while stopped
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !restart_i) |=> $stable(cnt_q));
    // R8: a fired key returns the count to zero
    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt_q == '0));
endmodule

// File: rtl/dual_wdog.sv
module dual_wdog
    import dwd_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              rst_req
);
    localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_FEED = ADDR_W'(4);

    logic [3:0] icode_q, rcode_q;
    logic       run_q, ien_q, ren_q;
    logic       iflag_q, rflag_q, rst_req_q;
    logic       ctrl_wr, feed_wr, restart;
    logic [1:0] hit;

    assign ctrl_wr = reg_wr && (reg_addr == OFS_CTRL);
    assign feed_wr = reg_wr && (reg_addr == OFS_FEED);

    dwd_feed_fsm u_feed (
        .clk       (clk),
        .rst_n     (rst_n),
        .feed_wr_i (feed_wr),
        .key_i     (reg_wdata[7:0]),
        .restart_o (restart)
    );

    dwd_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (run_q),
        .restart_i (restart),
        .code_i    ({rcode_q, icode_q}),
        .hit_o     (hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            icode_q <= '0;
            rcode_q <= '0;
            run_q   <= 1'b0;
            ien_q   <= 1'b0;
            ren_q   <= 1'b0;
        end else if (ctrl_wr) begin
            icode_q <= reg_wdata[B_ICODE +: 4];
            rcode_q <= reg_wdata[B_RCODE +: 4];
            run_q   <= reg_wdata[B_RUN];
            ien_q   <= reg_wdata[B_IEN];
            ren_q   <= reg_wdata[B_REN];
        end
    end

    // sticky flags: a threshold event wins over a clearing write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iflag_q   <= 1'b0;
            rflag_q   <= 1'b0;
            rst_req_q <= 1'b0;
        end else begin
            if (hit[0])                          iflag_q <= 1'b1;
            else if (ctrl_wr && !reg_wdata[B_IFLAG]) iflag_q <= 1'b0;
            if (hit[1])                          rflag_q <= 1'b1;
            else if (ctrl_wr && !reg_wdata[B_RFLAG]) rflag_q <= 1'b0;
            rst_req_q <= hit[1] && ren_q;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_CTRL) begin
            reg_rdata[B_ICODE +: 4] = icode_q;
            reg_rdata[B_RCODE +: 4] = rcode_q;
            reg_rdata[B_RUN]        = run_q;
            reg_rdata[B_IFLAG]      = iflag_q;
            reg_rdata[B_IEN]        = ien_q;
            reg_rdata[B_REN]        = ren_q;
            reg_rdata[B_RFLAG]      = rflag_q;
        end
    end

    assign irq     = iflag_q && ien_q;
    assign rst_req = rst_req_q;

    // R6: request is never two cycles long
    a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    // R6: request only with reset generation allowed
    a_r6_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(ren_q));
    // R4: no flag rises while stopped
    a_r4_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |=> (!$rose(iflag_q) && !$rose(rflag_q)));
    // R7: a flag survives any cycle without a clearing write
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (iflag_q && !(ctrl_wr && !reg_wdata[B_IFLAG])) |=> iflag_q);
endmodule

// File: tb/dual_wdog_test.sv
module dual_wdog_test;
    localparam int CNT_W = 17;
    localparam int MAXCYC = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, rst_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    dual_wdog #(.CNT_W(CNT_W), .ADDR_W(3)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .rst_req(rst_req)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick(1);
        reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    function automatic logic iflag();
        return reg_rdata[9];
    endfunction

    task automatic t_reset();
        do_reset();
        chk("R1 ctrl", reg_rdata, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 rst_req", {31'b0, rst_req}, 32'h0);
        reg_addr = 3'd4; #1;
        chk("R10 service reads 0", reg_rdata, 32'h0);
        reg_addr = 3'd0; #1;
    endtask

    task automatic t_readback();
        do_reset();
        wr(3'd0, 32'h0000_0C35);
        chk("R10 readback", reg_rdata, 32'h0000_0C35);
        wr(3'd0, 32'h8000_0E35);
        chk("R7 writing 1 sets no flag", reg_rdata, 32'h0000_0C35);
    endtask

    task automatic t_period(input int code);
        int p;
        p = 1 << (CNT_W - 1 - code);
        do_reset();
        wr(3'd0, 32'h100 | code);
        tick(p - 1);
        chk($sformatf("R2 code %0d before", code), {31'b0, iflag()}, 32'h0);
        tick(1);
        chk($sformatf("R2 code %0d at period", code), {31'b0, iflag()}, 32'h1);
    endtask

    task automatic t_reset_thr(input bit en);
        int seen;
        do_reset();
        wr(3'd0, (en ? 32'h800 : 32'h0) | 32'h100 | (13 << 4) | 15);
        tick(7);
        chk("R3 rflag before", {31'b0, reg_rdata[31]}, 32'h0);
        chk("R6 no early pulse", {31'b0, rst_req}, 32'h0);
        tick(1);
        chk("R3 rflag at period", {31'b0, reg_rdata[31]}, 32'h1);
        chk("R6 pulse at period", {31'b0, rst_req}, {31'b0, en});
        seen = 0;
        for (int i = 0; i < 10; i++) begin
            tick(1);
            if (rst_req) seen++;
        end
        chk("R6 pulse lasts one cycle", seen, 0);
        chk("R7 rflag sticky", {31'b0, reg_rdata[31]}, 32'h1);
    endtask

    task automatic t_irq();
        do_reset();
        wr(3'd0, 32'h100 | 15);
        tick(2);
        chk("R2 flag", {31'b0, iflag()}, 32'h1);
        chk("R5 irq masked", {31'b0, irq}, 32'h0);
        wr(3'd0, 32'h700 | 15);
        chk("R5 irq on", {31'b0, irq}, 32'h1);
        chk("R7 flag kept by writing 1", {31'b0, iflag()}, 32'h1);
        wr(3'd0, 32'h500 | 15);
        chk("R7 flag cleared by 0", {31'b0, iflag()}, 32'h0);
        chk("R5 irq off", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_hold();
        do_reset();
        wr(3'd0, 32'h10C);
        tick(9);
        wr(3'd0, 32'h00C);
        tick(40);
        chk("R4 no flag while stopped", {31'b0, iflag()}, 32'h0);
        wr(3'd0, 32'h10C);
        tick(5);
        chk("R4 count held, not cleared (before)", {31'b0, iflag()}, 32'h0);
        tick(1);
        chk("R4 count held, not cleared (at)", {31'b0, iflag()}, 32'h1);
    endtask

    task automatic t_feed_ok();
        do_reset();
        wr(3'd0, 32'h10C);
        tick(10);
        wr(3'd4, 32'h1234_56A5);
        wr(3'd4, 32'hABCD_005A);
        tick(15);
        chk("R8 restarted (before)", {31'b0, iflag()}, 32'h0);
        tick(1);
        chk("R8 restarted (at)", {31'b0, iflag()}, 32'h1);
    endtask

    task automatic t_feed_bad(input logic [7:0] k0, input logic [7:0] k1,
                              input logic [7:0] k2, input int n, input string tag);
        logic [7:0] ks [3];
        ks[0] = k0; ks[1] = k1; ks[2] = k2;
        do_reset();
        wr(3'd0, 32'h10C);
        tick(4);
        for (int i = 0; i < n; i++) wr(3'd4, {24'h0, ks[i]});
        tick(16 - 4 - n - 1);
        chk({"R9 no restart before ", tag}, {31'b0, iflag()}, 32'h0);
        tick(1);
        chk({"R9 no restart at ", tag}, {31'b0, iflag()}, 32'h1);
    endtask

    initial begin
        t_reset();
        t_readback();
        t_period(15);
        t_period(12);
        t_period(0);
        t_reset_thr(1'b1);
        t_reset_thr(1'b0);
        t_irq();
        t_hold();
        t_feed_ok();
        t_feed_bad(8'hA5, 8'hA5, 8'h5A, 3, "double arm");
        t_feed_bad(8'hA5, 8'h3C, 8'h5A, 3, "foreign");
        t_feed_bad(8'h5A, 8'hA5, 8'h00, 2, "reversed");
        t_feed_bad(8'h5A, 8'h00, 8'h00, 1, "lone fire");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (MAXCYC) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule